// File: doc/BRIEF.md
# Cartridge Mode-Select Host Interface

This block sits between the host bus and the external-memory window of a banking cartridge controller. The host writes a 4-bit mode into a control address range. The mode sets what the external-memory window does on later accesses. The window can act as plain RAM, as RAM the host may read but not write, or as a constant all-ones value. It can also carry a command to a command engine, return the engine's answer, show a handshake flag, or report an infrared-detect flag.

Only the three top address bits and data bits 6..0 reach the block. Bit 7 of every value the block itself returns reads 1. The block drives the RAM chip-select and write-enable. It presents the command word, a one-cycle start pulse and the ready flag to a separate command engine. That engine sends back a response nybble and a completion pulse.

Top module: `cart_mode_host`

## Requirements
- R1: After synchronous reset the mode is 0x0, the command word is zero, the semaphore reads ready (1) and `cmd_start` is low.
- R2: A write with `bus_addr_hi` = 3'b000 stores `bus_wdata[3:0]` as the mode. Bits 7..4 of the written value have no effect.
- R3: In mode 0x0, a window read (`bus_addr_hi` = 3'b101) asserts `ram_cs` and returns `ram_rdata`. A window write asserts neither `ram_cs` nor `ram_we`.
- R4: In mode 0xA, window reads and writes assert `ram_cs`. Writes also assert `ram_we`, and reads return `ram_rdata`.
- R5: In modes 0x1 to 0x9 and 0xF, a window read returns 0xFF and `ram_cs` stays low.
- R6: In mode 0xB, a window write loads `cmd_code` from bits 6..4 and `cmd_arg` from bits 3..0, ignoring bit 7. A window read returns {1, cmd_code, cmd_arg}.
- R7: In mode 0xC, a window read returns {1, cmd_code, rsp_nyb}.
- R8: In mode 0xD, a window read returns {1, cmd_code, 3'b000, ready}.
- R9: In mode 0xD, a window write with bit 0 clear while ready raises `cmd_start` for exactly the one cycle after the write. Ready then reads 0 until `eng_done` pulses.
- R10: In mode 0xD, a write with bit 0 set, or any write while not ready, leaves ready unchanged and gives no `cmd_start`.
- R11: In mode 0xE, a window read returns 0xFE with `ir_detect` in bit 0.
- R12: Accesses whose `bus_addr_hi` is neither 3'b000 nor 3'b101 change no state, keep `ram_cs` low and read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_hi | input | 3 | Host address bits 15..13 |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data for the current access |
| ram_rdata | input | 8 | Data from the external RAM |
| ram_cs | output | 1 | RAM chip-select |
| ram_we | output | 1 | RAM write-enable |
| cmd_code | output | 3 | Command field to the engine |
| cmd_arg | output | 4 | Operand field to the engine |
| cmd_start | output | 1 | One-cycle request to execute the command |
| rsp_nyb | input | 4 | Response nybble from the engine |
| eng_done | input | 1 | Engine completion pulse, sets ready |
| ir_detect | input | 1 | Infrared-detect flag |

## Verification
The bench writes mode values with junk in the upper nybble. A design that decoded all eight data bits would then land in a wrong mode and return the wrong window data. In the read-only mode it writes to the window and watches `ram_we` and `ram_cs`, which a design that reused the read/write gating would wrongly assert. It clears the semaphore twice, once while ready and once while busy, and writes a set bit 0. A design that retriggered or latched any write would emit an extra `cmd_start` or drop ready. It also accesses unmapped address ranges and then reads back the mode, which a loose three-bit decode would have changed.

// File: rtl/cmh_pkg.sv
package cmh_pkg;
    localparam int ADDR_HI_W = 3;
    localparam int DATA_W    = 8;
    localparam int NYB_W     = 4;
    localparam int CMD_W     = 3;
    localparam int WORD_W    = CMD_W + NYB_W;

    localparam logic [NYB_W-1:0] MODE_RAM_RO = 4'h0;
    localparam logic [NYB_W-1:0] MODE_RAM_RW = 4'hA;
    localparam logic [NYB_W-1:0] MODE_CMD_WR = 4'hB;
    localparam logic [NYB_W-1:0] MODE_RSP_RD = 4'hC;
    localparam logic [NYB_W-1:0] MODE_SEM    = 4'hD;
    localparam logic [NYB_W-1:0] MODE_IR     = 4'hE;

    typedef enum logic [2:0] {
        WK_RAM_RO,
        WK_RAM_RW,
        WK_CMD,
        WK_RSP,
        WK_SEM,
        WK_IR,
        WK_ONES
    } win_kind_e;

    typedef struct packed {
        logic [CMD_W-1:0] code;
        logic [NYB_W-1:0] arg;
    } cmd_word_t;

    function automatic win_kind_e classify(input logic [NYB_W-1:0] m);
        case (m)
            MODE_RAM_RO: classify = WK_RAM_RO;
            MODE_RAM_RW: classify = WK_RAM_RW;
            MODE_CMD_WR: classify = WK_CMD;
            MODE_RSP_RD: classify = WK_RSP;
            MODE_SEM:    classify = WK_SEM;
            MODE_IR:     classify = WK_IR;
            default:     classify = WK_ONES;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(input logic [CMD_W-1:0] code,
                                                      input logic [NYB_W-1:0] low);
        pack_status = {1'b1, code, low};
    endfunction
endpackage

// File: rtl/cmh_mode_reg.sv
module cmh_mode_reg
    import cmh_pkg::*;
#(
    parameter logic [NYB_W-1:0] RESET_MODE = 4'h0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic [NYB_W-1:0] wr_nyb,
    output logic [NYB_W-1:0] mode,
    output win_kind_e        kind
);
    logic [NYB_W-1:0] mode_q;

    always_ff @(posedge clk) begin
        if (rst)          mode_q <= RESET_MODE;
        else if (ctrl_we) mode_q <= wr_nyb;
    end

    assign mode = mode_q;
    assign kind = classify(mode_q);

    // R2 / R12: the mode only moves on a control-range write
    assert_mode_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !ctrl_we |=> $stable(mode_q));
endmodule

// File: rtl/cmh_mailbox.sv
module cmh_mailbox
    import cmh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic              sem_we,
    input  logic [WORD_W-1:0] wr_bits,
    input  logic              eng_done,
    output cmd_word_t         cmd_word,
    output logic              sem_ready,
    output logic              start_pulse
);
    cmd_word_t cmd_q;
    logic      ready_q;
    logic      start_q;
    logic      fire;

    assign fire = sem_we && ready_q && !wr_bits[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            ready_q <= 1'b1;
            start_q <= 1'b0;
        end else begin
            start_q <= fire;
            if (cmd_we) cmd_q <= cmd_word_t'(wr_bits);
            if (fire)          ready_q <= 1'b0;
            else if (eng_done) ready_q <= 1'b1;
        end
    end

    assign cmd_word    = cmd_q;
    assign sem_ready   = ready_q;
    assign start_pulse = start_q;

    // R9: a start request is seen only while the engine is busy
    assert_start_busy_R9: assert property (@(posedge clk) disable iff (rst)
        start_q |-> !ready_q);
    // R9: the start request lasts one cycle
    assert_start_single_R9: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !start_q);
    // R10: a write while busy cannot make ready return
    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (sem_we && !ready_q && !eng_done) |=> !ready_q && !start_q);
    // R9: ready comes back only after a completion pulse
    assert_ready_src_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_q) |-> $past(eng_done));
endmodule

// File: rtl/cmh_window_mux.sv
module cmh_window_mux
    import cmh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  win_kind_e         kind,
    input  logic              win_rd,
    input  logic              win_wr,
    input  logic [DATA_W-1:0] ram_rdata,
    input  cmd_word_t         cmd_word,
    input  logic [NYB_W-1:0]  rsp_nyb,
    input  logic              sem_ready,
    input  logic              ir_flag,
    output logic [DATA_W-1:0] rdata,
    output logic              ram_cs,
    output logic              ram_we
);
    logic ram_ok_rd;
    logic ram_ok_wr;

    assign ram_ok_rd = (kind == WK_RAM_RW) || (kind == WK_RAM_RO);
    assign ram_ok_wr = (kind == WK_RAM_RW);

    always_comb begin
        ram_cs = (win_rd && ram_ok_rd) || (win_wr && ram_ok_wr);
        ram_we = win_wr && ram_ok_wr;
    end

    always_comb begin
        rdata = '1;
        if (win_rd) begin
            case (kind)
                WK_RAM_RO, WK_RAM_RW: rdata = ram_rdata;
                WK_CMD:  rdata = pack_status(cmd_word.code, cmd_word.arg);
                WK_RSP:  rdata = pack_status(cmd_word.code, rsp_nyb);
                WK_SEM:  rdata = pack_status(cmd_word.code, {3'b000, sem_ready});
                WK_IR:   rdata = {{(DATA_W-1){1'b1}}, ir_flag};
                default: rdata = '1;
            endcase
        end
    end

    // R3 / R4: RAM writes happen only in the read/write mode
    assert_we_mode_R4: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (kind == WK_RAM_RW) && ram_cs);
    // R3: the read-only mode never selects RAM on a write
    assert_ro_nowrite_R3: assert property (@(posedge clk) disable iff (rst)
        (kind == WK_RAM_RO && win_wr) |-> !ram_cs);
    // R5: values from the controller itself float bit 7 high
    assert_top_bit_R5: assert property (@(posedge clk) disable iff (rst)
        (win_rd && !ram_ok_rd) |-> rdata[DATA_W-1]);
endmodule

// File: rtl/cart_mode_host.sv
module cart_mode_host
    import cmh_pkg::*;
#(
    parameter logic [ADDR_HI_W-1:0] CTRL_SEL   = 3'b000,
    parameter logic [ADDR_HI_W-1:0] WIN_SEL    = 3'b101,
    parameter logic [NYB_W-1:0]     RESET_MODE = 4'h0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_HI_W-1:0] bus_addr_hi,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [DATA_W-1:0]    ram_rdata,
    output logic                 ram_cs,
    output logic                 ram_we,
    output logic [CMD_W-1:0]     cmd_code,
    output logic [NYB_W-1:0]     cmd_arg,
    output logic                 cmd_start,
    input  logic [NYB_W-1:0]     rsp_nyb,
    input  logic                 eng_done,
    input  logic                 ir_detect
);
    logic              ctrl_hit, win_hit;
    logic              ctrl_we, win_rd, win_wr;
    logic [WORD_W-1:0] wbits;
    logic [NYB_W-1:0]  mode;
    win_kind_e         kind;
    cmd_word_t         cword;
    logic              ready;

    assign ctrl_hit = (bus_addr_hi == CTRL_SEL);
    assign win_hit  = (bus_addr_hi == WIN_SEL);
    assign ctrl_we  = ctrl_hit && bus_wr;
    assign win_rd   = win_hit && bus_rd;
    assign win_wr   = win_hit && bus_wr;
    assign wbits    = bus_wdata[WORD_W-1:0];

    cmh_mode_reg #(.RESET_MODE(RESET_MODE)) u_mode (
        .clk     (clk),
        .rst     (rst),
        .ctrl_we (ctrl_we),
        .wr_nyb  (bus_wdata[NYB_W-1:0]),
        .mode    (mode),
        .kind    (kind)
    );

    cmh_mailbox u_mbox (
        .clk         (clk),
        .rst         (rst),
        .cmd_we      (win_wr && kind == WK_CMD),
        .sem_we      (win_wr && kind == WK_SEM),
        .wr_bits     (wbits),
        .eng_done    (eng_done),
        .cmd_word    (cword),
        .sem_ready   (ready),
        .start_pulse (cmd_start)
    );

    cmh_window_mux u_mux (
        .clk       (clk),
        .rst       (rst),
        .kind      (kind),
        .win_rd    (win_rd),
        .win_wr    (win_wr),
        .ram_rdata (ram_rdata),
        .cmd_word  (cword),
        .rsp_nyb   (rsp_nyb),
        .sem_ready (ready),
        .ir_flag   (ir_detect),
        .rdata     (bus_rdata),
        .ram_cs    (ram_cs),
        .ram_we    (ram_we)
    );

    assign cmd_code = cword.code;
    assign cmd_arg  = cword.arg;

    // R12: accesses outside the window never select RAM
    assert_cs_window_R12: assert property (@(posedge clk) disable iff (rst)
        !win_hit |-> !ram_cs);
    // R6: the command word changes only on a window write
    assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !win_wr |=> $stable(cword));
    // R2: a control write lands its low nybble as the mode
    assert_mode_load_R2: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> mode == $past(bus_wdata[NYB_W-1:0]));
endmodule

// File: tb/sim_cart_mode_host.sv
module sim_cart_mode_host;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr_hi = 3'b000;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] ram_rdata = 8'h5A;
    logic       ram_cs, ram_we;
    logic [2:0] cmd_code;
    logic [3:0] cmd_arg;
    logic       cmd_start;
    logic [3:0] rsp_nyb = 4'h9;
    logic       eng_done = 1'b0;
    logic       ir_detect = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sbq[$];

    always #4 clk = ~clk;

    cart_mode_host u0 (
        .clk(clk), .rst(rst), .bus_addr_hi(bus_addr_hi), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ram_rdata(ram_rdata), .ram_cs(ram_cs), .ram_we(ram_we),
        .cmd_code(cmd_code), .cmd_arg(cmd_arg), .cmd_start(cmd_start),
        .rsp_nyb(rsp_nyb), .eng_done(eng_done), .ir_detect(ir_detect)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares read data against the scoreboard queue
    always @(negedge clk) begin
        #2;
        if (bus_rd && sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            chk(bus_rdata, it.exp, it.tag);
        end
    end

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d,
                             input logic exp_cs, input logic exp_we, input string tag);
        @(negedge clk);
        bus_addr_hi = a; bus_wdata = d; bus_wr = 1'b1;
        #1;
        chk({7'b0, ram_cs}, {7'b0, exp_cs}, {tag, " ram_cs on write"});
        chk({7'b0, ram_we}, {7'b0, exp_we}, {tag, " ram_we on write"});
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_mode(input logic [7:0] d);
        bus_write(3'b000, d, 1'b0, 1'b0, "R2 mode write");
    endtask

    task automatic bus_read(input logic [2:0] a, input logic [7:0] exp,
                            input logic exp_cs, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr_hi = a; bus_rd = 1'b1;
        it.exp = exp; it.tag = tag;
        sbq.push_back(it);
        #1;
        chk({7'b0, ram_cs}, {7'b0, exp_cs}, {tag, " ram_cs on read"});
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk({5'b0, cmd_code}, 8'h00, "R1 cmd_code after reset");
        chk({4'b0, cmd_arg}, 8'h00, "R1 cmd_arg after reset");
        chk({7'b0, cmd_start}, 8'h00, "R1 cmd_start after reset");
        bus_read(3'b101, 8'h5A, 1'b1, "R1 reset mode reads RAM");
        set_mode(8'hFD);
        bus_read(3'b101, 8'h81, 1'b0, "R1 ready after reset");

        // R2 / R5 ones modes, upper nybble junk
        set_mode(8'hF3);
        bus_read(3'b101, 8'hFF, 1'b0, "R5 mode 3");
        set_mode(8'h79);
        bus_read(3'b101, 8'hFF, 1'b0, "R5 mode 9");
        set_mode(8'h0F);
        bus_read(3'b101, 8'hFF, 1'b0, "R5 mode F");
        set_mode(8'h51);
        bus_read(3'b101, 8'hFF, 1'b0, "R2 R5 mode 1 upper bits ignored");

        // R3 read-only RAM
        set_mode(8'hA0);
        bus_write(3'b101, 8'h12, 1'b0, 1'b0, "R3 ro write");
        ram_rdata = 8'hC3;
        bus_read(3'b101, 8'hC3, 1'b1, "R3 ro read");

        // R4 read/write RAM
        set_mode(8'h0A);
        bus_write(3'b101, 8'h34, 1'b1, 1'b1, "R4 rw write");
        ram_rdata = 8'h5A;
        bus_read(3'b101, 8'h5A, 1'b1, "R4 rw read");

        // R6 command mailbox, bit 7 ignored
        set_mode(8'h0B);
        bus_write(3'b101, 8'hD7, 1'b0, 1'b0, "R6 cmd write");
        chk({5'b0, cmd_code}, 8'h05, "R6 cmd_code");
        chk({4'b0, cmd_arg}, 8'h07, "R6 cmd_arg");
        bus_read(3'b101, 8'hD7, 1'b0, "R6 cmd readback");
        bus_write(3'b101, 8'h62, 1'b0, 1'b0, "R6 cmd write 2");
        bus_read(3'b101, 8'hE2, 1'b0, "R6 cmd readback 2");

        // R7 response
        set_mode(8'h0C);
        bus_read(3'b101, 8'hE9, 1'b0, "R7 response read");
        rsp_nyb = 4'h1;
        bus_read(3'b101, 8'hE1, 1'b0, "R7 response read 2");

        // R8 / R9 / R10 semaphore
        set_mode(8'h0D);
        bus_read(3'b101, 8'hE1, 1'b0, "R8 sem read ready");
        bus_write(3'b101, 8'hFF, 1'b0, 1'b0, "R10 set-bit write");
        chk({7'b0, cmd_start}, 8'h00, "R10 no start on set bit");
        bus_read(3'b101, 8'hE1, 1'b0, "R10 ready unchanged");
        bus_write(3'b101, 8'hFE, 1'b0, 1'b0, "R9 clear write");
        chk({7'b0, cmd_start}, 8'h01, "R9 start pulse");
        @(negedge clk);
        chk({7'b0, cmd_start}, 8'h00, "R9 start one cycle");
        bus_read(3'b101, 8'hE0, 1'b0, "R9 busy read");
        bus_write(3'b101, 8'hFE, 1'b0, 1'b0, "R10 clear while busy");
        chk({7'b0, cmd_start}, 8'h00, "R10 no start while busy");
        bus_read(3'b101, 8'hE0, 1'b0, "R10 still busy");
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
        bus_read(3'b101, 8'hE1, 1'b0, "R9 ready after done");

        // R11 infrared
        set_mode(8'h0E);
        ir_detect = 1'b1;
        bus_read(3'b101, 8'hFF, 1'b0, "R11 ir high");
        ir_detect = 1'b0;
        bus_read(3'b101, 8'hFE, 1'b0, "R11 ir low");

        // R12 unmapped ranges
        bus_write(3'b010, 8'h0A, 1'b0, 1'b0, "R12 stray write");
        bus_write(3'b110, 8'h0B, 1'b0, 1'b0, "R12 stray write 2");
        bus_read(3'b011, 8'hFF, 1'b0, "R12 stray read");
        bus_read(3'b101, 8'hFE, 1'b0, "R12 mode kept");
        chk({5'b0, cmd_code}, 8'h06, "R12 cmd kept");

        repeat (3) @(negedge clk);
        if (sbq.size() != 0) begin
            checks++; failures++;
            $display("FAIL scoreboard actual=%0d expected=0 pending", sbq.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule